// File: doc/BRIEF.md
# Routed Interrupt Controller with Atomic Set/Clear

This block gathers sixteen interrupt request lines for a small embedded processor and presents them as two outputs: one towards the host and one towards the local core. Each source has a pending status bit. Each source also has an enable bit, a trigger-mode bit and two routing bits, one for each output. Software reaches all of this through a simple register port with one write channel and one read channel. Pending and enable bits are changed through dedicated write-one-to-set and write-one-to-clear addresses, so no read-modify-write sequence is needed.

The source positions are fixed. Bit 0 is the general-purpose timer. Bit 1 is the watchdog. Bit 2 is command arrival. Bit 3 is the context switch. Bit 4 is halt. Bit 5 is the external error. Bits 6 and 7 are software interrupts. Bits 8 to 15 are external lines.

A top-level host status bit summarises the host-routed pending sources. A separate top-level enable bit gates the host output pin. The block does no vectoring and no priority encoding.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset the block is in a clean state. Pending, enable, mode, routing and the top-level enable are all 0, so every source is in edge mode. Both outputs and `rd_data` are 0.
- R2: A write to address 0 sets every pending bit whose `wr_data` bit is 1. Bits written as 0 are left unchanged. Address 2 reads the pending vector in bits 15:0.
- R3: A write to address 1 clears every pending bit whose `wr_data` bit is 1. A hardware trigger (an edge, or a high level input) in the same cycle as the clear keeps that bit pending.
- R4: A write to address 4 sets enable bits and a write to address 5 clears them. In both cases only the bits written as 1 are affected. Address 6 reads the enable vector.
- R5: Address 3 holds the mode vector and is readable. A 1 selects level mode and a 0 selects edge mode. An edge-mode source becomes pending on a 0-to-1 input transition, and it stays pending after the input falls.
- R6: A level-mode source is made pending again on every cycle its input is high, so a clear has no lasting effect until the input is low. The pending bit stays set after the input falls, until it is cleared. An edge-mode input that is held high does not set the bit again after a clear.
- R7: Address 7 holds the routing word. Bit i routes source i to the host. Bit 16+i routes source i to the core. `irq_core` is the OR over i of pending[i] AND enable[i] AND routing[16+i].
- R8: Address 8 bit 0 reads the host summary, which is the OR over i of pending[i] AND enable[i] AND routing[i], taken before the top-level gate. Address 9 bit 0 is the top-level enable. `irq_host` is the summary AND the top-level enable.
- R9: Both outputs are registered. An output reflects a state change one clock after the edge that made the change. `rd_data` shows the register selected by `rd_addr` one clock later, and it includes writes committed at earlier edges.
- R10: Addresses 0, 1, 4, 5 and 10 to 15 read as 0. Writes to addresses 10 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Raw interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Registered read data |
| irq_host | output | 1 | Interrupt towards the host |
| irq_core | output | 1 | Interrupt towards the local core |

## Verification
A write or an input change is captured at the first rising edge after it is driven. That edge updates pending, enable, mode and routing state. Read data appears one edge later, and each output changes one edge after the state change that drives it.

The bench drives every stimulus on the falling edge and samples on a later falling edge. A read issued right after a write therefore sees the new state. Each output is checked at two points. The first is on the falling edge just after the committing edge, where the old value must still be present. The second is one edge later, where the new value must appear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQC_AW = 4;

  typedef enum logic [IRQC_AW-1:0] {
    A_STAT_SET = 4'd0,
    A_STAT_CLR = 4'd1,
    A_STAT     = 4'd2,
    A_MODE     = 4'd3,
    A_MASK_SET = 4'd4,
    A_MASK_CLR = 4'd5,
    A_MASK     = 4'd6,
    A_ROUTE    = 4'd7,
    A_TOP_STAT = 4'd8,
    A_TOP_MASK = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic level_mode,
  input  logic sw_set,
  input  logic sw_clr,
  output logic pending
);
  logic in_q;
  logic trig;

  // Level mode: the input itself is the trigger. Edge mode: a 0-to-1 transition.
  assign trig = level_mode ? irq_in : (irq_in & ~in_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q    <= 1'b0;
      pending <= 1'b0;
    end else begin
      in_q    <= irq_in;
      pending <= sw_set | trig | (pending & ~sw_clr);
    end
  end

  a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
    sw_set |=> pending);
  a_r3_clear_lands: assert property (@(posedge clk) disable iff (rst)
    (sw_clr && !sw_set && !irq_in) |=> !pending);
  a_r3_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && irq_in && !in_q) |=> pending);
  a_r6_level_holds: assert property (@(posedge clk) disable iff (rst)
    (level_mode && irq_in) |=> pending);
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int DW   = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IRQC_AW-1:0]    wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic [IRQC_AW-1:0]    rd_addr,
  input  logic [NSRC-1:0]       pending,
  input  logic                  host_pending,
  output logic [NSRC-1:0]       stat_set,
  output logic [NSRC-1:0]       stat_clr,
  output logic [NSRC-1:0]       mask,
  output logic [NSRC-1:0]       mode,
  output logic [2*NSRC-1:0]     route,
  output logic                  top_mask,
  output logic [DW-1:0]         rd_data
);
  localparam int RW = 2 * NSRC;

  logic [NSRC-1:0] wd;
  assign wd = wr_data[NSRC-1:0];

  // Set and clear strobes for the pending bits, one-cycle wide.
  assign stat_set = (wr_en && wr_addr == A_STAT_SET) ? wd : '0;
  assign stat_clr = (wr_en && wr_addr == A_STAT_CLR) ? wd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask     <= '0;
      mode     <= '0;
      route    <= '0;
      top_mask <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MASK_SET: mask     <= mask | wd;
        A_MASK_CLR: mask     <= mask & ~wd;
        A_MODE:     mode     <= wd;
        A_ROUTE:    route    <= wr_data[RW-1:0];
        A_TOP_MASK: top_mask <= wr_data[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      case (rd_addr)
        A_STAT:     rd_data[NSRC-1:0] <= pending;
        A_MODE:     rd_data[NSRC-1:0] <= mode;
        A_MASK:     rd_data[NSRC-1:0] <= mask;
        A_ROUTE:    rd_data[RW-1:0]   <= route;
        A_TOP_STAT: rd_data[0]        <= host_pending;
        A_TOP_MASK: rd_data[0]        <= top_mask;
        default:    ;
      endcase
    end
  end

  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (mask == '0 && mode == '0 && route == '0 && !top_mask));
  a_r4_mask_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_MASK_SET) |=> ((mask & $past(wd)) == $past(wd)));
  a_r4_mask_clr_sticks: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_MASK_CLR) |=> ((mask & $past(wd)) == '0));
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
  parameter int NSRC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   pending,
  input  logic [NSRC-1:0]   mask,
  input  logic [2*NSRC-1:0] route,
  input  logic              top_mask,
  output logic              host_pending,
  output logic              irq_host,
  output logic              irq_core
);
  logic [NSRC-1:0] hit_host;
  logic [NSRC-1:0] hit_core;

  // Per-source qualification: pending, enabled and routed to that destination.
  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign hit_host[g] = pending[g] & mask[g] & route[g];
    assign hit_core[g] = pending[g] & mask[g] & route[NSRC + g];
  end

  assign host_pending = |hit_host;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_host <= 1'b0;
      irq_core <= 1'b0;
    end else begin
      irq_host <= host_pending & top_mask;
      irq_core <= |hit_core;
    end
  end

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> (!irq_host && !irq_core));
  a_r8_top_gate: assert property (@(posedge clk) disable iff (rst)
    !top_mask |=> !irq_host);
  a_r7_unrouted_core: assert property (@(posedge clk) disable iff (rst)
    (route[2*NSRC-1:NSRC] == '0) |=> !irq_core);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int DW   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC-1:0]     irq_in,
  input  logic                wr_en,
  input  logic [IRQC_AW-1:0]  wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [IRQC_AW-1:0]  rd_addr,
  output logic [DW-1:0]       rd_data,
  output logic                irq_host,
  output logic                irq_core
);
  logic [NSRC-1:0]   stat_set;
  logic [NSRC-1:0]   stat_clr;
  logic [NSRC-1:0]   mask;
  logic [NSRC-1:0]   mode;
  logic [2*NSRC-1:0] route;
  logic              top_mask;
  logic [NSRC-1:0]   pending;
  logic              host_pending;

  irqc_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pending(pending), .host_pending(host_pending),
    .stat_set(stat_set), .stat_clr(stat_clr), .mask(mask), .mode(mode),
    .route(route), .top_mask(top_mask), .rd_data(rd_data)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irqc_src_cell u_cell (
      .clk(clk), .rst(rst), .irq_in(irq_in[s]), .level_mode(mode[s]),
      .sw_set(stat_set[s]), .sw_clr(stat_clr[s]), .pending(pending[s])
    );
  end

  irqc_route #(.NSRC(NSRC)) u_route (
    .clk(clk), .rst(rst), .pending(pending), .mask(mask), .route(route),
    .top_mask(top_mask), .host_pending(host_pending),
    .irq_host(irq_host), .irq_core(irq_core)
  );
endmodule

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] irq_in;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq_host;
  logic        irq_core;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_host(irq_host), .irq_core(irq_core)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] expv;
    logic [31:0] rt;
    rst = 1'b1; irq_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq_host", {31'b0, irq_host}, 0);
    chk("R1 irq_core", {31'b0, irq_core}, 0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R1 register after reset", v, 0);
    end

    // R2: accumulate set writes, bits written 0 untouched
    expv = 0;
    for (int i = 0; i < 16; i++) begin
      wr(4'd0, 32'(1) << i);
      expv |= 32'(1) << i;
      rd(4'd2, v);
      chk("R2 set accumulates", v, expv);
    end
    // R3: partial then full clear
    wr(4'd1, 32'h0000_00FF); rd(4'd2, v); chk("R3 partial clear", v, 32'h0000_FF00);
    wr(4'd1, 32'h0000_FFFF); rd(4'd2, v); chk("R3 full clear", v, 0);

    // R5: edge mode latches and stays after input falls
    for (int i = 0; i < 16; i++) begin
      irq_in = 16'(1) << i;
      @(negedge clk);
      irq_in = '0;
      @(negedge clk);
      rd(4'd2, v); chk("R5 edge latched", v, 32'(1) << i);
      wr(4'd1, 32'(1) << i);
      rd(4'd2, v); chk("R5 edge cleared", v, 0);
    end

    // R3: rising edge in the clear cycle keeps the bit
    irq_in = 16'h0004;
    wr(4'd1, 32'h0000_0004);
    rd(4'd2, v); chk("R3 edge beats clear", v, 32'h4);
    // R6: held-high edge input does not reassert after clear
    wr(4'd1, 32'h0000_0004);
    rd(4'd2, v); chk("R6 edge held high cleared", v, 0);
    irq_in = '0;
    @(negedge clk);

    // R5/R6: level mode
    wr(4'd3, 32'h0000_FFFF);
    rd(4'd3, v); chk("R5 mode readback", v, 32'h0000_FFFF);
    irq_in = 16'h00F0;
    @(negedge clk);
    wr(4'd1, 32'h0000_FFFF);
    rd(4'd2, v); chk("R6 clear ignored while high", v, 32'h0000_00F0);
    irq_in = '0;
    @(negedge clk);
    rd(4'd2, v); chk("R6 level sticky after fall", v, 32'h0000_00F0);
    wr(4'd1, 32'h0000_FFFF);
    rd(4'd2, v); chk("R6 clear after fall", v, 0);
    wr(4'd3, 32'h0);

    // R4: enable set/clear
    wr(4'd4, 32'h0000_00A5); rd(4'd6, v); chk("R4 mask set", v, 32'h00A5);
    wr(4'd4, 32'h0000_0100); rd(4'd6, v); chk("R4 mask set keeps", v, 32'h01A5);
    wr(4'd5, 32'h0000_0005); rd(4'd6, v); chk("R4 mask clear", v, 32'h01A0);
    wr(4'd5, 32'h0000_FFFF); rd(4'd6, v); chk("R4 mask all clear", v, 0);

    // R7/R8/R9: every source with every routing combination
    wr(4'd9, 32'h1);
    for (int i = 0; i < 16; i++) begin
      for (int r = 0; r < 4; r++) begin
        rt = ((32'(r) & 1) << i) | (((32'(r) >> 1) & 1) << (16 + i));
        wr(4'd7, rt);
        wr(4'd4, 32'(1) << i);
        wr(4'd0, 32'(1) << i);
        chk("R9 host one cycle lag", {31'b0, irq_host}, 0);
        chk("R9 core one cycle lag", {31'b0, irq_core}, 0);
        @(negedge clk);
        chk("R8 host routed", {31'b0, irq_host}, 32'(r) & 1);
        chk("R7 core routed", {31'b0, irq_core}, (32'(r) >> 1) & 1);
        rd(4'd8, v); chk("R8 host summary", v, 32'(r) & 1);
        wr(4'd5, 32'(1) << i);
        @(negedge clk);
        chk("R4 masked host", {31'b0, irq_host}, 0);
        chk("R4 masked core", {31'b0, irq_core}, 0);
        wr(4'd1, 32'(1) << i);
      end
    end

    // R8: top-level gate
    wr(4'd7, 32'h0001_0001);
    wr(4'd4, 32'h1);
    wr(4'd0, 32'h1);
    @(negedge clk);
    chk("R8 host on", {31'b0, irq_host}, 1);
    chk("R7 core on", {31'b0, irq_core}, 1);
    wr(4'd9, 32'h0);
    @(negedge clk);
    chk("R8 host gated", {31'b0, irq_host}, 0);
    chk("R8 core unaffected", {31'b0, irq_core}, 1);
    rd(4'd8, v); chk("R8 summary ungated", v, 1);
    rd(4'd9, v); chk("R8 top mask reads 0", v, 0);

    // R10: unmapped and write-only addresses
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); chk("R10 unmapped reads 0", v, 0);
    rd(4'd2, v); chk("R10 status untouched", v, 1);
    rd(4'd6, v); chk("R10 mask untouched", v, 1);
    rd(4'd7, v); chk("R10 route untouched", v, 32'h0001_0001);
    rd(4'd0, v); chk("R10 write-only reads 0", v, 0);
    rd(4'd5, v); chk("R10 write-only reads 0", v, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule